// File: doc/BRIEF.md
# Activatable I/O Base Decoder

This block holds the configuration state that switches a two-port peripheral on and places it in host I/O space. A small configuration bus writes and reads three registers: an enable register and the two bytes of the I/O base address. When the peripheral is enabled and the programmed base lies inside the allowed window, host I/O reads and writes are decoded against that base. The block then raises one of two chip selects: one for the data port and one for the command/status port.

The enable bit also drives two other outputs. It passes or blocks the peripheral's interrupt line, and it drives a power-down indication that is asserted while the peripheral is disabled. Configuration reads are combinational from the index. Configuration writes take effect on the next rising clock edge. Chip selects, the interrupt and the power-down output are combinational from the inputs and the stored state.

Top module: `io_win_dec`

## Requirements
- R1: After reset the enable bit is 0, the base address is 0x0330, `pwr_dn_o` is 1, `irq_o` is 0 and neither chip select is asserted.
- R2: Configuration index 0x30 holds the enable bit in bit 0. It reads back as {7'b0, enable}, and writes to bits 7:1 have no effect.
- R3: Index 0x60 holds base bits 15:8 and index 0x61 holds base bits 7:0. Bit 0 of the base is forced to 0 on write, so index 0x61 always reads back with bit 0 clear.
- R4: Any other configuration index reads as 0x00. A write to such an index changes no stored register.
- R5: `data_cs_o` is 1 exactly when the block is enabled, the base is in range, `io_rd_i` or `io_wr_i` is 1, and `io_addr_i` equals the base.
- R6: `cmd_cs_o` is 1 exactly when the block is enabled, the base is in range, a strobe is active, and `io_addr_i` equals base+1.
- R7: With both `io_rd_i` and `io_wr_i` low, neither chip select is asserted, whatever the address.
- R8: With the enable bit 0, neither chip select is asserted, even for a matching address with a strobe active.
- R9: The base is in range only when it lies within 0x0100 to 0x0FFE inclusive. Outside that window nothing is decoded.
- R10: `irq_o` equals `periph_irq_i` while the block is enabled and is 0 while it is disabled.
- R11: `pwr_dn_o` is the inverse of the enable bit.
- R12: Configuration writes occur only on a rising clock edge with `cfg_we_i` high. `cfg_rdata_o` follows `cfg_idx_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_idx_i | input | 8 | Configuration register index |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for `cfg_idx_i` |
| io_addr_i | input | 16 | Host I/O address |
| io_rd_i | input | 1 | Host I/O read strobe |
| io_wr_i | input | 1 | Host I/O write strobe |
| periph_irq_i | input | 1 | Interrupt request from the peripheral |
| data_cs_o | output | 1 | Data port chip select |
| cmd_cs_o | output | 1 | Command/status port chip select |
| irq_o | output | 1 | Gated interrupt to the host |
| pwr_dn_o | output | 1 | Power-down indication, high while disabled |

## Verification
The assertions assume that the configuration index and data are stable around the clock edge and that a host strobe is meaningful only together with a valid address. They do not assume that read and write strobes are exclusive. The stimulus therefore drives every input half a cycle away from the rising edge and sometimes raises both strobes together. High-byte writes are biased toward small values so that the base often lands inside the decode window. Directed writes place the base on both window edges and just outside them, and also probe indices other than the three defined ones.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
  localparam int unsigned CFG_IDX_W = 8;
  localparam int unsigned CFG_DAT_W = 8;
  localparam int unsigned BASE_W    = 2 * CFG_DAT_W;

  typedef logic [CFG_IDX_W-1:0] cfg_idx_t;
  typedef logic [CFG_DAT_W-1:0] cfg_dat_t;
  typedef logic [BASE_W-1:0]    io_addr_t;
endpackage

// File: rtl/io_win_cfg_regs.sv
module io_win_cfg_regs
  import io_win_pkg::*;
#(
  parameter cfg_idx_t    IDX_ACT     = 8'h30,
  parameter cfg_idx_t    IDX_BASE_HI = 8'h60,
  parameter cfg_idx_t    IDX_BASE_LO = 8'h61,
  parameter io_addr_t    RST_BASE    = 16'h0330,
  parameter int unsigned ALIGN_BITS  = 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  cfg_idx_t idx_i,
  input  cfg_dat_t wdata_i,
  output cfg_dat_t rdata_o,
  output logic     active_o,
  output io_addr_t base_o
);
  localparam cfg_dat_t ALIGN_MASK = {CFG_DAT_W{1'b1}} << ALIGN_BITS;

  logic     act_q;
  io_addr_t base_q;

  logic hit_act, hit_hi, hit_lo;
  assign hit_act = (idx_i == IDX_ACT);
  assign hit_hi  = (idx_i == IDX_BASE_HI);
  assign hit_lo  = (idx_i == IDX_BASE_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      base_q <= RST_BASE & io_addr_t'({BASE_W{1'b1}} << ALIGN_BITS);
    end else if (we_i) begin
      if (hit_act) act_q <= wdata_i[0];
      if (hit_hi)  base_q[BASE_W-1:CFG_DAT_W] <= wdata_i;
      if (hit_lo)  base_q[CFG_DAT_W-1:0] <= wdata_i & ALIGN_MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_act)     rdata_o = {{(CFG_DAT_W-1){1'b0}}, act_q};
    else if (hit_hi) rdata_o = base_q[BASE_W-1:CFG_DAT_W];
    else if (hit_lo) rdata_o = base_q[CFG_DAT_W-1:0];
  end

  assign active_o = act_q;
  assign base_o   = base_q;

  // R3
  base_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_q[ALIGN_BITS-1:0] == '0);

  // R3
  base_lo_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_lo) |=> (base_q[CFG_DAT_W-1:0] == ($past(wdata_i) & ALIGN_MASK)));

  // R4
  unk_idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit_act && !hit_hi && !hit_lo) |=> ($stable(base_q) && $stable(act_q)));

  // R12
  no_we_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(base_q) && $stable(act_q)));
endmodule

// File: rtl/io_win_addr_match.sv
module io_win_addr_match
  import io_win_pkg::*;
#(
  parameter int unsigned N_PORTS  = 2,
  parameter io_addr_t    BASE_MIN = 16'h0100,
  parameter io_addr_t    BASE_MAX = 16'h0FFE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  io_addr_t           base_i,
  input  io_addr_t           addr_i,
  input  logic               rd_i,
  input  logic               wr_i,
  output logic               in_range_o,
  output logic [N_PORTS-1:0] cs_o
);
  localparam int unsigned SEL_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  logic strobe, block_hit;

  assign in_range_o = (base_i >= BASE_MIN) && (base_i <= BASE_MAX);
  assign strobe     = rd_i | wr_i;
  assign block_hit  = en_i && in_range_o && strobe &&
                      (addr_i[BASE_W-1:SEL_W] == base_i[BASE_W-1:SEL_W]);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign cs_o[p] = block_hit && (addr_i[SEL_W-1:0] == SEL_W'(p));
  end

  // R5
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));

  // R7
  cs_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cs_o) |-> (rd_i || wr_i));
endmodule

// File: rtl/io_win_gate.sv
module io_win_gate (
  input  logic active_i,
  input  logic irq_i,
  output logic irq_o,
  output logic pwr_dn_o
);
  assign irq_o    = active_i & irq_i;
  assign pwr_dn_o = ~active_i;
endmodule

// File: rtl/io_win_dec.sv
module io_win_dec
  import io_win_pkg::*;
#(
  parameter cfg_idx_t IDX_ACT     = 8'h30,
  parameter cfg_idx_t IDX_BASE_HI = 8'h60,
  parameter cfg_idx_t IDX_BASE_LO = 8'h61,
  parameter io_addr_t RST_BASE    = 16'h0330,
  parameter io_addr_t BASE_MIN    = 16'h0100,
  parameter io_addr_t BASE_MAX    = 16'h0FFE
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_idx_i,
  input  logic [7:0]  cfg_wdata_i,
  output logic [7:0]  cfg_rdata_o,
  input  logic [15:0] io_addr_i,
  input  logic        io_rd_i,
  input  logic        io_wr_i,
  input  logic        periph_irq_i,
  output logic        data_cs_o,
  output logic        cmd_cs_o,
  output logic        irq_o,
  output logic        pwr_dn_o
);
  localparam int unsigned N_PORTS    = 2;
  localparam int unsigned ALIGN_BITS = $clog2(N_PORTS);

  logic               active;
  io_addr_t           base;
  logic               in_range;
  logic [N_PORTS-1:0] cs;

  io_win_cfg_regs #(
    .IDX_ACT(IDX_ACT), .IDX_BASE_HI(IDX_BASE_HI), .IDX_BASE_LO(IDX_BASE_LO),
    .RST_BASE(RST_BASE), .ALIGN_BITS(ALIGN_BITS)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .idx_i(cfg_idx_i),
    .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o), .active_o(active), .base_o(base)
  );

  io_win_addr_match #(
    .N_PORTS(N_PORTS), .BASE_MIN(BASE_MIN), .BASE_MAX(BASE_MAX)
  ) u_match (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(active), .base_i(base),
    .addr_i(io_addr_i), .rd_i(io_rd_i), .wr_i(io_wr_i),
    .in_range_o(in_range), .cs_o(cs)
  );

  io_win_gate u_gate (
    .active_i(active), .irq_i(periph_irq_i), .irq_o(irq_o), .pwr_dn_o(pwr_dn_o)
  );

  assign data_cs_o = cs[0];
  assign cmd_cs_o  = cs[1];

  // R8
  cs_off_when_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_cs_o || cmd_cs_o) |-> !pwr_dn_o);

  // R9
  cs_base_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_cs_o || cmd_cs_o) |-> (in_range && base >= BASE_MIN && base <= BASE_MAX));

  // R10
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (periph_irq_i && !pwr_dn_o));

  // R6
  cmd_addr_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_cs_o |-> io_addr_i[0]);
endmodule

// File: tb/tb_io_win_dec.sv
`timescale 1ns/1ps
module tb_io_win_dec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_idx_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic [15:0] io_addr_i = '0;
  logic        io_rd_i = 1'b0;
  logic        io_wr_i = 1'b0;
  logic        periph_irq_i = 1'b0;
  logic        data_cs_o, cmd_cs_o, irq_o, pwr_dn_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic        m_act;
  logic [15:0] m_base;

  always #2.5 clk_i = ~clk_i;

  io_win_dec dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_cs(input logic [15:0] a, input logic rd, input logic wr);
    logic hit;
    hit = m_act && (rd || wr) && m_base >= 16'h0100 && m_base <= 16'h0FFE &&
          a[15:1] == m_base[15:1];
    return {hit && a[0], hit && !a[0]};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] idx);
    case (idx)
      8'h30:   return {7'b0, m_act};
      8'h60:   return m_base[15:8];
      8'h61:   return m_base[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic cfg_wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    case (idx)
      8'h30: m_act = d[0];
      8'h60: m_base[15:8] = d;
      8'h61: m_base[7:0] = d & 8'hFE;
      default: ;
    endcase
  endtask

  task automatic cfg_chk(input logic [7:0] idx, input string req);
    @(negedge clk_i);
    cfg_idx_i = idx;
    #1 chk(req, {8'h0, cfg_rdata_o}, {8'h0, exp_rd(idx)});
  endtask

  task automatic io_chk(input logic [15:0] a, input logic rd, input logic wr,
                        input logic irq, input string req);
    logic [1:0] e;
    @(negedge clk_i);
    io_addr_i = a; io_rd_i = rd; io_wr_i = wr; periph_irq_i = irq;
    #1;
    e = exp_cs(a, rd, wr);
    chk(req, {14'h0, cmd_cs_o, data_cs_o}, {14'h0, e});
    chk("R10", {15'h0, irq_o}, {15'h0, irq && m_act});
    chk("R11", {15'h0, pwr_dn_o}, {15'h0, !m_act});
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    m_act = 1'b0; m_base = 16'h0330;
    #12 rst_ni = 1'b1;

    // R1 reset state
    #1;
    chk("R1 pwr_dn", {15'h0, pwr_dn_o}, 16'h1);
    cfg_chk(8'h60, "R1 base hi");
    cfg_chk(8'h61, "R1 base lo");
    cfg_chk(8'h30, "R1 act");
    io_chk(16'h0330, 1'b1, 1'b0, 1'b1, "R1 no cs");

    // R8 disabled: matching address with strobe still not decoded
    io_chk(16'h0331, 1'b0, 1'b1, 1'b0, "R8");

    // R2 upper bits of the enable register are dropped
    cfg_wr(8'h30, 8'hFF);
    cfg_chk(8'h30, "R2");
    io_chk(16'h0330, 1'b1, 1'b0, 1'b1, "R5");
    io_chk(16'h0331, 1'b0, 1'b1, 1'b1, "R6");
    io_chk(16'h0331, 1'b0, 1'b0, 1'b0, "R7");
    io_chk(16'h0332, 1'b1, 1'b1, 1'b0, "R5 miss");

    // R3 odd low byte is aligned down
    cfg_wr(8'h61, 8'h45);
    cfg_chk(8'h61, "R3");
    io_chk(16'h0344, 1'b1, 1'b0, 1'b0, "R3 data");
    io_chk(16'h0345, 1'b1, 1'b0, 1'b0, "R3 cmd");

    // R4 unknown indices
    cfg_wr(8'h62, 8'hAA);
    cfg_wr(8'h31, 8'h00);
    cfg_chk(8'h62, "R4");
    cfg_chk(8'h30, "R4 act kept");
    cfg_chk(8'h61, "R4 base kept");

    // R9 window edges
    cfg_wr(8'h60, 8'h01); cfg_wr(8'h61, 8'h00);
    io_chk(16'h0100, 1'b1, 1'b0, 1'b0, "R9 min");
    cfg_wr(8'h60, 8'h00); cfg_wr(8'h61, 8'hFE);
    io_chk(16'h00FE, 1'b1, 1'b0, 1'b0, "R9 below");
    io_chk(16'h00FF, 1'b0, 1'b1, 1'b0, "R9 below");
    cfg_wr(8'h60, 8'h0F); cfg_wr(8'h61, 8'hFE);
    io_chk(16'h0FFF, 1'b0, 1'b1, 1'b0, "R9 max");
    cfg_wr(8'h60, 8'h10); cfg_wr(8'h61, 8'h00);
    io_chk(16'h1000, 1'b1, 1'b0, 1'b0, "R9 above");

    // R12 no write without cfg_we_i
    @(negedge clk_i);
    cfg_idx_i = 8'h60; cfg_wdata_i = 8'h03;
    @(negedge clk_i);
    cfg_chk(8'h60, "R12");

    // R8 deactivate again
    cfg_wr(8'h60, 8'h03); cfg_wr(8'h61, 8'h30);
    cfg_wr(8'h30, 8'h00);
    io_chk(16'h0330, 1'b1, 1'b1, 1'b1, "R8 off");
    cfg_wr(8'h30, 8'h01);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned sel;
      sel = $urandom_range(0, 9);
      if (sel < 2) begin
        logic [7:0] idx, d;
        case ($urandom_range(0, 4))
          0: begin idx = 8'h30; d = 8'($urandom); end
          1: begin idx = 8'h60; d = 8'($urandom_range(0, 17)); end
          2: begin idx = 8'h61; d = 8'($urandom); end
          default: begin idx = 8'($urandom); d = 8'($urandom); end
        endcase
        if (idx == 8'h30 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
        cfg_wr(idx, d);
        cfg_chk(idx, "R12 rand cfg");
      end else begin
        logic [15:0] a;
        a = ($urandom_range(0, 3) == 0) ? 16'($urandom)
                                        : m_base + 16'($urandom_range(0, 3)) - 16'd1;
        io_chk(a, 1'($urandom), 1'($urandom), 1'($urandom), "R5/R6 rand");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule